// File: doc/BRIEF.md
# Serial Test Pattern Generator

This block produces a serial test stream for bit-error-rate measurement. Each cycle in which `bit_en` is high, it produces one pattern bit, which appears one clock later on `tx_bit` with `tx_valid` high. The stream can be one of five pseudorandom sequences. It can also be a QRSS-style variant of the 2^20−1 sequence that caps runs of zeros, a programmable repetitive word of 17 to 32 bits, or an alternating-word pattern built from the two halves of a programmed word.

Pattern select, length code and pattern word are held in shadow registers. They are captured only on a rising edge of `cfg_load`. Any change on those inputs has no effect until the next rising edge. Each capture also restarts the pattern from its first bit and seeds the shift register with all ones. The output inversion control `cfg_inv` is applied at once, after the pattern has been generated.

Top module: `bert_patgen`

## Requirements
- R1: While reset is asserted and after its release, `tx_valid` and `tx_bit` are 0. With no load yet received, the block generates the 2^7−1 sequence from an all-ones seed.
- R2: A bit is emitted for exactly each cycle with `bit_en` high and no load edge. The bit appears on `tx_bit`, with `tx_valid` high, in the following cycle. `tx_valid` is low in every other cycle.
- R3: `cfg_sel`, `cfg_len` and `cfg_word` are captured only on a rising edge of `cfg_load`, and changes between edges have no effect. In the cycle of the load edge no bit is emitted, even if `bit_en` is high.
- R4: Each pseudorandom sequence uses a history d1..dN that holds the sequence's previous N raw bits, with d1 the newest, and that starts as all ones. Each new raw bit is d(a) XOR d(N). The select codes give (a,N) as follows: 000 → (6,7), 001 → (14,15), 010 → (17,20), 100 → (18,23), 101 → (28,31).
- R5: Select code 011 emits the (17,20) sequence. When the previous 14 emitted bits were all zero, it emits a 1 in place of the raw bit. The raw bit still enters the history, so no run of zeros is longer than 14.
- R6: Select code 110 repeats `cfg_word` bits 0 upward, with period 17 + `cfg_len` (code 0000 gives 17 bits, code 1111 gives 32). The length code has no effect in any other mode.
- R7: A repeat shorter than 17 bits is obtained by programming a multiple of it, for example a 6-bit pattern written three times with length code 0001 (18 bits).
- R8: Select code 111 emits `cfg_word[15:0]`, least significant bit first, ALT_RPT times in a row. It then emits `cfg_word[31:16]` the same way, and this cycle repeats.
- R9: When `cfg_inv` is high in the cycle a bit is generated, the emitted bit is the complement of the pattern bit, including the forced ones of R5. The control takes effect without a load.
- R10: A load edge restarts the selected pattern from its first bit, even when the configuration is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bit_en | input | 1 | Request one pattern bit this cycle |
| cfg_sel | input | 3 | Pattern select code |
| cfg_len | input | CODE_W | Repetitive length code (period 17 + code) |
| cfg_word | input | WORD_W | Repetitive / alternating pattern word |
| cfg_inv | input | 1 | Invert emitted bits |
| cfg_load | input | 1 | Configuration capture strobe (rising edge) |
| tx_bit | output | 1 | Serial pattern bit |
| tx_valid | output | 1 | `tx_bit` holds a new bit |

## Verification
The bench uses the default 32-bit word, 4-bit length code and 14-zero QRSS cap. It overrides ALT_RPT to 2, so the complete alternating cycle of 64 bits, including its half switch and wrap, is seen in under a hundred bits. The 3000-bit QRSS run lets the zero cap engage and be compared against an independent history model. The repetitive tests reach both ends of the length code, 17 and 32 bits, plus the 6-bit sub-pattern case.

// File: rtl/bert_patgen.sv
module bert_patgen #(
  parameter int WORD_W   = 32,
  parameter int CODE_W   = 4,
  parameter int LEN_BASE = 17,
  parameter int ALT_RPT  = 4,
  parameter int QRSS_RUN = 14,
  parameter int SR_W     = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic [2:0]        cfg_sel,
  input  logic [CODE_W-1:0] cfg_len,
  input  logic [WORD_W-1:0] cfg_word,
  input  logic              cfg_inv,
  input  logic              cfg_load,
  output logic              tx_bit,
  output logic              tx_valid
);

  localparam int PW    = $clog2(WORD_W);
  localparam int ALT_W = WORD_W / 2;
  localparam int AW    = $clog2(ALT_W);
  localparam int RW    = $clog2(ALT_RPT + 1);
  localparam int ZW    = $clog2(QRSS_RUN + 1);
  localparam int TW    = $clog2(SR_W);

  localparam logic [2:0] M_P7   = 3'd0;
  localparam logic [2:0] M_P15  = 3'd1;
  localparam logic [2:0] M_P20  = 3'd2;
  localparam logic [2:0] M_QRSS = 3'd3;
  localparam logic [2:0] M_P23  = 3'd4;
  localparam logic [2:0] M_P31  = 3'd5;
  localparam logic [2:0] M_REP  = 3'd6;
  localparam logic [2:0] M_ALT  = 3'd7;

  logic [2:0]        sel_q;
  logic [CODE_W-1:0] code_q;
  logic [WORD_W-1:0] word_q;
  logic              load_d;
  logic [SR_W-1:0]   sr;
  logic [PW-1:0]     ptr;
  logic [AW-1:0]     apos;
  logic [RW-1:0]     arep;
  logic              ahalf;
  logic [ZW-1:0]     zc;
  logic              bit_q, valid_q;

  logic [TW-1:0] tap_a, tap_b;
  logic          fb, gen;

  wire load_rise = cfg_load & ~load_d;
  wire advance   = bit_en & ~load_rise;
  wire is_prbs   = (sel_q != M_REP) && (sel_q != M_ALT);
  wire [PW-1:0] rep_last = PW'(LEN_BASE - 1) + PW'(code_q);
  wire [ALT_W-1:0] lo_word = word_q[ALT_W-1:0];
  wire [ALT_W-1:0] hi_word = word_q[WORD_W-1 -: ALT_W];
  wire qrss_force = (sel_q == M_QRSS) && (zc == ZW'(QRSS_RUN));

  always_comb begin
    case (sel_q)
      M_P7:          begin tap_a = TW'(5);  tap_b = TW'(6);  end
      M_P15:         begin tap_a = TW'(13); tap_b = TW'(14); end
      M_P20, M_QRSS: begin tap_a = TW'(16); tap_b = TW'(19); end
      M_P23:         begin tap_a = TW'(17); tap_b = TW'(22); end
      default:       begin tap_a = TW'(27); tap_b = TW'(30); end
    endcase
  end

  assign fb = sr[tap_a] ^ sr[tap_b];

  always_comb begin
    case (sel_q)
      M_REP:   gen = word_q[ptr];
      M_ALT:   gen = ahalf ? hi_word[apos] : lo_word[apos];
      M_QRSS:  gen = qrss_force | fb;
      default: gen = fb;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_d  <= 1'b0;
      sel_q   <= M_P7;
      code_q  <= '0;
      word_q  <= '0;
      sr      <= '1;
      ptr     <= '0;
      apos    <= '0;
      arep    <= '0;
      ahalf   <= 1'b0;
      zc      <= '0;
      bit_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      load_d  <= cfg_load;
      valid_q <= advance;
      if (load_rise) begin
        sel_q  <= cfg_sel;
        code_q <= cfg_len;
        word_q <= cfg_word;
        sr     <= '1;
        ptr    <= '0;
        apos   <= '0;
        arep   <= '0;
        ahalf  <= 1'b0;
        zc     <= '0;
      end else if (bit_en) begin
        bit_q <= gen ^ cfg_inv;
        if (is_prbs) sr <= {sr[SR_W-2:0], fb};
        if (sel_q == M_REP) ptr <= (ptr == rep_last) ? '0 : ptr + 1'b1;
        if (sel_q == M_ALT) begin
          if (apos == AW'(ALT_W - 1)) begin
            apos <= '0;
            if (arep == RW'(ALT_RPT - 1)) begin
              arep  <= '0;
              ahalf <= ~ahalf;
            end else begin
              arep <= arep + 1'b1;
            end
          end else begin
            apos <= apos + 1'b1;
          end
        end
        if (sel_q == M_QRSS) zc <= gen ? '0 : zc + 1'b1;
      end
    end
  end

  assign tx_bit   = bit_q;
  assign tx_valid = valid_q;

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> tx_valid);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> !tx_valid);
  assert_load_no_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_rise |=> !tx_valid);
  assert_cfg_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !load_rise |=> ($stable(sel_q) && $stable(code_q) && $stable(word_q)));
  assert_seed_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_rise |=> (sr == '1));
  assert_qrss_force_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (qrss_force && advance) |=> (tx_bit != $past(cfg_inv)));
  assert_zero_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    zc <= ZW'(QRSS_RUN));
  assert_ptr_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == M_REP) |-> (ptr <= rep_last));
  assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load_rise |=> (ptr == '0 && apos == '0 && !ahalf && zc == '0));

endmodule

// File: tb/bert_patgen_tb.sv
`timescale 1ns/1ps
module bert_patgen_tb_top;

  localparam int RPT = 2;
  localparam int HW  = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_en = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [3:0]  cfg_len = '0;
  logic [31:0] cfg_word = '0;
  logic        cfg_inv = 1'b0;
  logic        cfg_load = 1'b0;
  logic        tx_bit, tx_valid;

  always #4 clk = ~clk;

  bert_patgen #(.ALT_RPT(RPT)) dut_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .cfg_sel(cfg_sel),
    .cfg_len(cfg_len), .cfg_word(cfg_word), .cfg_inv(cfg_inv),
    .cfg_load(cfg_load), .tx_bit(tx_bit), .tx_valid(tx_valid));

  int total = 0, bad = 0;
  bit    exp_q[$];
  string tag_q[$];
  bit    rec[$];

  logic [2:0]  m_sel;
  logic [3:0]  m_code;
  logic [31:0] m_word;
  logic [63:0] hist;
  int          m_pos, m_zrun;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic model_reset(input logic [2:0] s, input logic [3:0] c, input logic [31:0] w);
    m_sel = s; m_code = c; m_word = w; hist = '1; m_pos = 0; m_zrun = 0;
  endtask

  task automatic model_bit(output bit b);
    int a, n, per;
    bit raw;
    case (m_sel)
      3'd0: begin a = 6;  n = 7;  end
      3'd1: begin a = 14; n = 15; end
      3'd4: begin a = 18; n = 23; end
      3'd5: begin a = 28; n = 31; end
      default: begin a = 17; n = 20; end
    endcase
    if (m_sel == 3'd6) begin
      b = m_word[m_pos % (17 + int'(m_code))];
      m_pos++;
    end else if (m_sel == 3'd7) begin
      per = HW * RPT;
      b = m_word[((m_pos / per) % 2) * HW + (m_pos % HW)];
      m_pos++;
    end else begin
      raw = hist[a-1] ^ hist[n-1];
      hist = {hist[62:0], raw};
      b = raw;
      if (m_sel == 3'd3) begin
        if (m_zrun == 14) b = 1'b1;
        m_zrun = b ? 0 : m_zrun + 1;
      end
    end
    b = b ^ cfg_inv;
  endtask

  always @(negedge clk) begin
    if (rst_n && tx_valid) begin
      rec.push_back(tx_bit);
      if (exp_q.size() == 0) begin
        check(1'b0, "R2/R3", "unexpected tx_valid", 1, 0);
      end else begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(tx_bit == e, t, "tx_bit", tx_bit, e);
      end
    end
  end

  task automatic emit(input int n, input string tag, input int gap);
    bit b;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_en = 1'b1;
      model_bit(b);
      exp_q.push_back(b);
      tag_q.push_back(tag);
      if (gap > 0) begin
        @(negedge clk);
        bit_en = 1'b0;
        repeat (gap - 1) @(negedge clk);
      end
    end
    @(negedge clk);
    bit_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic load(input logic [2:0] s, input logic [3:0] c, input logic [31:0] w,
                      input bit en_during);
    @(negedge clk);
    bit_en = en_during;
    cfg_sel = s; cfg_len = c; cfg_word = w;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    bit_en = 1'b0;
    model_reset(s, c, w);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    check(1'b0, "R2", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int maxrun, run;
    bit okp;
    repeat (3) @(negedge clk);
    check(tx_valid == 1'b0, "R1", "tx_valid in reset", tx_valid, 0);
    check(tx_bit == 1'b0, "R1", "tx_bit in reset", tx_bit, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(tx_valid == 1'b0, "R1", "tx_valid after reset", tx_valid, 0);
    model_reset(3'd0, 4'd0, 32'd0);
    emit(40, "R1", 0);

    load(3'd0, 4'd9, 32'h0, 1'b0);
    emit(300, "R4", 0);
    load(3'd1, 4'd3, 32'h0, 1'b0);
    emit(200, "R4", 2);
    load(3'd2, 4'd0, 32'h0, 1'b0);
    emit(200, "R4", 0);
    load(3'd4, 4'd15, 32'h0, 1'b0);
    emit(200, "R2", 3);
    load(3'd5, 4'd0, 32'h0, 1'b0);
    emit(200, "R4", 0);

    load(3'd3, 4'd0, 32'h0, 1'b0);
    rec.delete();
    emit(3000, "R5", 0);
    maxrun = 0; run = 0;
    foreach (rec[k]) begin
      run = rec[k] ? 0 : run + 1;
      if (run > maxrun) maxrun = run;
    end
    check(maxrun <= 14, "R5", "longest zero run", maxrun, 14);

    load(3'd6, 4'd0, 32'hA5C3_9E17, 1'b0);
    emit(60, "R6", 0);
    load(3'd6, 4'd15, 32'h8001_F00D, 1'b0);
    emit(80, "R6", 1);
    load(3'd6, 4'd7, 32'h00C3_5A96, 1'b0);
    emit(60, "R6", 0);

    load(3'd6, 4'd1, {14'd0, 6'b101100, 6'b101100, 6'b101100}, 1'b0);
    rec.delete();
    emit(48, "R7", 0);
    okp = 1'b1;
    for (int k = 0; k + 6 < rec.size(); k++) if (rec[k] != rec[k+6]) okp = 1'b0;
    check(okp, "R7", "6-bit periodicity", okp, 1);
    check(rec.size() == 48, "R7", "bit count", rec.size(), 48);

    load(3'd7, 4'd5, 32'h3C0F_A5F1, 1'b0);
    emit(100, "R8", 0);

    load(3'd0, 4'd0, 32'h0, 1'b0);
    emit(20, "R9", 0);
    cfg_inv = 1'b1;
    emit(30, "R9", 0);
    cfg_inv = 1'b0;
    emit(10, "R9", 0);
    load(3'd3, 4'd0, 32'h0, 1'b0);
    cfg_inv = 1'b1;
    emit(600, "R9", 0);
    cfg_inv = 1'b0;

    load(3'd6, 4'd2, 32'h1234_5678, 1'b0);
    emit(10, "R3", 0);
    cfg_sel = 3'd0; cfg_len = 4'd9; cfg_word = 32'hFFFF_0000;
    emit(40, "R3", 0);
    load(3'd1, 4'd0, 32'h0, 1'b1);
    emit(30, "R3", 0);

    load(3'd6, 4'd4, 32'h0F0F_3355, 1'b0);
    emit(7, "R10", 0);
    load(3'd6, 4'd4, 32'h0F0F_3355, 1'b0);
    emit(30, "R10", 0);
    load(3'd5, 4'd0, 32'h0, 1'b0);
    emit(11, "R10", 0);
    load(3'd5, 4'd0, 32'h0, 1'b0);
    emit(40, "R10", 0);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R2", "undelivered bits", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule